// File: doc/BRIEF.md
# Lock-Gated Output Enable Controller

This block decides what a deserializer's parallel outputs do. Three conditions feed the decision: a power-up input, a count of received parallel-clock periods, and whether that clock is still toggling. The outputs can be in one of three modes. They are released (tri-stated at the pad), driven to zero, or passing the recovered data and a copy of the parallel clock. When power-up is low, the outputs are released and any lock progress is discarded. Once power-up goes high, the outputs are driven to zero. They stay at zero until a fixed number of parallel-clock rising edges has been counted. From then on, the data and the clock copy pass through.

The whole block runs on one free-running reference clock. The parallel clock and its data enter as sampled signals. They travel through a synchronizing pipeline of equal depth, so the data stays aligned with the clock level the block observes. An activity watchdog counts reference cycles since the last parallel-clock rising edge. If that count reaches a programmable timeout, the clock is considered lost or too slow. The outputs then return to zero and lock counting restarts from nothing. A polarity input selects whether the clock copy is passed straight or inverted, so downstream logic can latch on either edge.

Top module: `lock_gated_oe`

## Requirements
- R1: While `pwrUp` is low, the cycle after any reference edge that samples it low shows `outEn` = 0 and `dataOut` = 0 and `clkOut` = 0. This holds from any mode.
- R2: After `pwrUp` is sampled high, the next cycle shows `outEn` = 1. `dataOut` and `clkOut` stay at zero until lock is declared.
- R3: Lock is declared on the reference edge that detects the `LOCK_PERIODS`-th rising edge of the delayed parallel clock while acquiring. The clock level is `pclkIn` delayed by `SYNC_STAGES` reference cycles. From that edge on, `dataOut` equals `dataIn` delayed by `SYNC_STAGES` cycles.
- R4: Clock loss occurs when the idle count reaches `timeoutCycles`. The idle count is the number of reference cycles since the last detected rising edge, and it saturates. On clock loss, `dataOut` and `clkOut` return to zero while `outEn` stays 1. After the clock returns, a full `LOCK_PERIODS` edges are needed again. A clock that is too slow has the same effect as a stopped one.
- R5: `timeoutCycles` is a run-time input. With a parallel period of P reference cycles, a timeout of at most P-1 prevents lock, and a timeout of at least P allows it.
- R6: While passing, `clkOut` equals the delayed parallel-clock level when `invStrobe` = 0 and its inverse when `invStrobe` = 1.
- R7: The forcing of outputs to zero is lifted only on a reference edge that detects a parallel-clock rising edge.
- R8: Power-up may come before the parallel clock starts. Once the clock runs, lock follows after `LOCK_PERIODS` edges.
- R9: During and right after reset, `outEn` = 0, `dataOut` = 0 and `clkOut` = 0.
- R10: A power-down during acquisition discards the partial count. The next power-up needs the full `LOCK_PERIODS` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrUp | input | 1 | High enables the receiver; low releases the outputs |
| pclkIn | input | 1 | Received parallel-rate clock, sampled as data |
| invStrobe | input | 1 | 1 selects an inverted clock copy on `clkOut` |
| timeoutCycles | input | TW | Idle reference cycles that count as clock loss |
| dataIn | input | DW | Recovered parallel data |
| dataOut | output | DW | Gated parallel data |
| clkOut | output | 1 | Gated clock copy with selected polarity |
| outEn | output | 1 | Pad output enable; 0 means high impedance |

## Verification
The hardest condition to reach is the boundary between clock loss and normal running. The idle count reaches the timeout exactly on the cycle where a new rising edge is detected, so one cycle separates locking from never locking. The stimulus reaches this boundary in three ways. It keeps the parallel period fixed and moves `timeoutCycles` across the period length. It stretches the period past the timeout. It stops the clock outright. A behavioural reference model compares every output on every cycle through these transitions. Power-down is also dropped mid-acquisition, and power-up is raised with the clock stopped, to confirm that partial counts never survive.

// File: rtl/lockgate_pkg.sv
package lockgate_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_ACQ  = 2'd1,
    ST_PASS = 2'd2
  } lockState_e;

  typedef struct packed {
    logic outEn;
    logic forceLow;
  } outCtrl_t;
endpackage

// File: rtl/lockgate_outpath.sv
module lockgate_outpath
  import lockgate_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pclkIn,
  input  logic [DW-1:0] dataIn,
  input  logic          invStrobe,
  input  outCtrl_t      ctrl,
  output logic          clkLvl,
  output logic [DW-1:0] dataOut,
  output logic          clkOut,
  output logic          outEn
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] clkPipe;
  logic [DW-1:0]          dataPipe [SYNC_STAGES];

  // Clock level and data share one pipeline depth so they stay aligned.
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          clkPipe[0]  <= 1'b0;
          dataPipe[0] <= '0;
        end else begin
          clkPipe[0]  <= pclkIn;
          dataPipe[0] <= dataIn;
        end
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          clkPipe[g]  <= 1'b0;
          dataPipe[g] <= '0;
        end else begin
          clkPipe[g]  <= clkPipe[g-1];
          dataPipe[g] <= dataPipe[g-1];
        end
      end
    end
  end

  assign clkLvl  = clkPipe[LAST];
  assign dataOut = ctrl.forceLow ? '0 : dataPipe[LAST];
  assign clkOut  = ctrl.forceLow ? 1'b0 : (clkPipe[LAST] ^ invStrobe);
  assign outEn   = ctrl.outEn;
endmodule

// File: rtl/lockgate_ctrl.sv
module lockgate_ctrl
  import lockgate_pkg::*;
#(
  parameter int LOCK_PERIODS = 32800,
  parameter int TW           = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwrUp,
  input  logic          clkLvl,
  input  logic [TW-1:0] timeoutCycles,
  output outCtrl_t      ctrl
);
  localparam int CW = $clog2(LOCK_PERIODS + 1);
  localparam logic [TW-1:0] IDLE_MAX  = {TW{1'b1}};
  localparam logic [CW-1:0] LAST_EDGE = CW'(LOCK_PERIODS - 1);

  lockState_e    state, stateNext;
  logic          prevLvl;
  logic          clkRise;
  logic          clkLost;
  logic [TW-1:0] idleCnt;
  logic [CW-1:0] lockCnt;
  outCtrl_t      ctrlQ;

  assign clkRise = clkLvl & ~prevLvl;
  assign clkLost = (idleCnt >= timeoutCycles);

  // Activity watchdog: reference cycles since the last rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevLvl <= 1'b0;
      idleCnt <= '0;
    end else begin
      prevLvl <= clkLvl;
      if (clkRise)                idleCnt <= '0;
      else if (idleCnt != IDLE_MAX) idleCnt <= idleCnt + 1'b1;
    end
  end

  // Lock counter: only advances while acquiring with an active clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            lockCnt <= '0;
    else if (state != ST_ACQ || clkLost)   lockCnt <= '0;
    else if (clkRise)                      lockCnt <= lockCnt + 1'b1;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_OFF:  if (pwrUp) stateNext = ST_ACQ;
      ST_ACQ: begin
        if (!pwrUp) stateNext = ST_OFF;
        else if (clkRise && !clkLost && lockCnt == LAST_EDGE) stateNext = ST_PASS;
      end
      ST_PASS: begin
        if (!pwrUp)       stateNext = ST_OFF;
        else if (clkLost) stateNext = ST_ACQ;
      end
      default: stateNext = ST_OFF;
    endcase
  end

  // Entry to pass happens only on a detected edge, so release is boundary aligned.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_OFF;
      ctrlQ.outEn    <= 1'b0;
      ctrlQ.forceLow <= 1'b1;
    end else begin
      state          <= stateNext;
      ctrlQ.outEn    <= (stateNext != ST_OFF);
      ctrlQ.forceLow <= (stateNext != ST_PASS);
    end
  end

  assign ctrl = ctrlQ;

  assert_off_on_pwrdn_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrUp |=> (!ctrlQ.outEn && ctrlQ.forceLow));

  assert_release_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrlQ.forceLow) |-> $past(clkRise));

  assert_loss_forces_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clkLost |=> ctrlQ.forceLow);

  assert_lockcnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lockCnt <= CW'(LOCK_PERIODS));
endmodule

// File: rtl/lock_gated_oe.sv
module lock_gated_oe
  import lockgate_pkg::*;
#(
  parameter int DW           = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int LOCK_PERIODS = 32800,
  parameter int TW           = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwrUp,
  input  logic          pclkIn,
  input  logic          invStrobe,
  input  logic [TW-1:0] timeoutCycles,
  input  logic [DW-1:0] dataIn,
  output logic [DW-1:0] dataOut,
  output logic          clkOut,
  output logic          outEn
);
  outCtrl_t ctrl;
  logic     clkLvl;

  lockgate_ctrl #(.LOCK_PERIODS(LOCK_PERIODS), .TW(TW)) uCtrl (
    .clk(clk), .rst_n(rst_n), .pwrUp(pwrUp), .clkLvl(clkLvl),
    .timeoutCycles(timeoutCycles), .ctrl(ctrl)
  );

  lockgate_outpath #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) uPath (
    .clk(clk), .rst_n(rst_n), .pclkIn(pclkIn), .dataIn(dataIn),
    .invStrobe(invStrobe), .ctrl(ctrl), .clkLvl(clkLvl),
    .dataOut(dataOut), .clkOut(clkOut), .outEn(outEn)
  );
endmodule

// File: tb/tb_lock_gated_oe.sv
`timescale 1ns/1ps
module tb_lock_gated_oe;
  localparam int DW = 8, S = 2, NLOCK = 6, TW = 6;

  logic clk = 1'b0, rst_n = 1'b0, pwrUp = 1'b0, pclkIn = 1'b0, invStrobe = 1'b0;
  logic [TW-1:0] timeoutCycles = 6'd8;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut;
  logic clkOut, outEn;

  int checks = 0, errors = 0, cycles = 0;
  string curReq = "R9";
  bit cmpOn = 0, clkRun = 0, fixData = 0;
  int half = 2, pCnt = 0;

  always #2.5 clk = ~clk;

  lock_gated_oe #(.DW(DW), .SYNC_STAGES(S), .LOCK_PERIODS(NLOCK), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .pwrUp(pwrUp), .pclkIn(pclkIn), .invStrobe(invStrobe),
    .timeoutCycles(timeoutCycles), .dataIn(dataIn), .dataOut(dataOut),
    .clkOut(clkOut), .outEn(outEn));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Stimulus for the parallel clock and data, driven at the falling edge.
  always @(negedge clk) begin
    if (clkRun) begin
      pCnt++;
      if (pCnt >= half) begin pclkIn <= ~pclkIn; pCnt = 0; end
    end
    if (!fixData) dataIn <= DW'($urandom);
  end

  // Behavioural reference model, stepped per reference edge, compared shortly after.
  logic mQClk[$];
  logic [DW-1:0] mQData[$];
  bit mPrev, mFL = 1, mOE = 0;
  int mIdle = 0, mCnt = 0, mState = 0;
  always begin
    @(posedge clk);
    if (!rst_n) begin
      mQClk.delete(); mQData.delete();
      for (int i = 0; i < S; i++) begin mQClk.push_back(1'b0); mQData.push_back('0); end
      mPrev = 0; mIdle = 0; mCnt = 0; mState = 0; mFL = 1; mOE = 0;
    end else begin
      bit lvl, rise, lost;
      int nxt;
      lvl  = mQClk[S-1];
      rise = lvl && !mPrev;
      lost = (mIdle >= int'(timeoutCycles));
      nxt  = mState;
      if (mState == 0) begin if (pwrUp) nxt = 1; end
      else if (mState == 1) begin
        if (!pwrUp) nxt = 0;
        else if (rise && !lost && mCnt == NLOCK - 1) nxt = 2;
      end else begin
        if (!pwrUp) nxt = 0; else if (lost) nxt = 1;
      end
      if (mState != 1 || lost) mCnt = 0; else if (rise) mCnt++;
      if (rise) mIdle = 0; else if (mIdle < (1 << TW) - 1) mIdle++;
      mPrev = lvl;
      mQClk.push_front(pclkIn); void'(mQClk.pop_back());
      mQData.push_front(dataIn); void'(mQData.pop_back());
      mState = nxt; mOE = (nxt != 0); mFL = (nxt != 2);
    end
    #1;
    if (cmpOn) begin
      check({curReq, " outEn"}, 32'(outEn), 32'(mOE));
      check({curReq, " dataOut"}, 32'(dataOut), mFL ? 32'd0 : 32'(mQData[S-1]));
      check({curReq, " clkOut"}, 32'(clkOut), mFL ? 32'd0 : 32'(mQClk[S-1] ^ invStrobe));
    end
  end

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectMode(string req, bit expEn, bit expPass);
    fixData = 1; dataIn <= 8'hA5;
    waitCyc(S + 1);
    check({req, " mode outEn"}, 32'(outEn), 32'(expEn));
    check({req, " mode data"}, 32'(dataOut), expPass ? 32'hA5 : 32'h0);
    fixData = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    // R9: reset state
    check("R9 outEn", 32'(outEn), 0); check("R9 dataOut", 32'(dataOut), 0);
    check("R9 clkOut", 32'(clkOut), 0);
    rst_n = 1; cmpOn = 1;
    waitCyc(2);
    check("R9 after reset outEn", 32'(outEn), 0);
    // R2 / R3: acquire then pass
    curReq = "R2"; clkRun = 1; pwrUp = 1;
    waitCyc(2);
    check("R2 outEn", 32'(outEn), 1); check("R2 dataOut", 32'(dataOut), 0);
    waitCyc(10); expectMode("R2", 1, 0);
    curReq = "R3"; waitCyc(30); expectMode("R3", 1, 1);
    // R6: clock copy polarity
    curReq = "R6"; waitCyc(12); invStrobe = 1; waitCyc(12); invStrobe = 0; waitCyc(4);
    // R4: stopped clock, then relock
    curReq = "R4"; clkRun = 0; waitCyc(14); expectMode("R4 stop", 1, 0);
    clkRun = 1; waitCyc(8); expectMode("R4 restart", 1, 0);
    waitCyc(30); expectMode("R4 relock", 1, 1);
    half = 6; waitCyc(40); expectMode("R4 slow", 1, 0);
    half = 2; waitCyc(40); expectMode("R4 fast again", 1, 1);
    // R5: timeout at the period boundary
    curReq = "R5"; timeoutCycles = 6'd3; waitCyc(60); expectMode("R5 short", 1, 0);
    timeoutCycles = 6'd4; waitCyc(40); expectMode("R5 equal", 1, 1);
    timeoutCycles = 6'd8;
    // R1: power-down from pass
    curReq = "R1"; pwrUp = 0; waitCyc(1);
    check("R1 outEn", 32'(outEn), 0); check("R1 dataOut", 32'(dataOut), 0);
    check("R1 clkOut", 32'(clkOut), 0);
    waitCyc(5);
    // R10: interrupted acquisition
    curReq = "R10"; pwrUp = 1; waitCyc(14); pwrUp = 0; waitCyc(3); pwrUp = 1;
    waitCyc(14); expectMode("R10 partial", 1, 0);
    waitCyc(20); expectMode("R10 full", 1, 1);
    // R8: power-up before the clock runs
    curReq = "R8"; pwrUp = 0; clkRun = 0; waitCyc(5); pwrUp = 1; waitCyc(20);
    expectMode("R8 no clock", 1, 0);
    clkRun = 1; waitCyc(40); expectMode("R8 locked", 1, 1);
    cmpOn = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule